// File: doc/BRIEF.md
# Four-Channel Timer Capture Unit

This block takes a snapshot of a free-running 16-bit timer into one of four capture registers. Each channel has its own input pin and its own trigger source. In hardware mode, a chosen edge on the channel's pin starts the capture. In software mode, a bus write to the low byte of the channel's capture register starts it, and the written data is thrown away. Pins are asynchronous. Each one passes through a two-flop synchroniser, and its edges are found on the synchronised level.

The registers sit behind a small byte-wide port. The port's read data is combinational. Hardware captures set a sticky per-channel flag, which is also driven out as an interrupt request. Software clears a flag by writing a one to its bit.

Top module: `capture_unit`

## Requirements
- R1: After reset, all capture registers, the configuration byte and the flags read as zero, and `irqFlag` is 0.
- R2: In hardware mode, a pin level first sampled at clock edge k is captured at edge k+2. The captured value is the `timerVal` present at edge k+2.
- R3: Configuration bit 4+c selects the active pin edge of channel c: 0 for rising, 1 for falling. The opposite edge captures nothing.
- R4: Configuration bit c set to 1 puts channel c in software mode. In that mode, a write to address 2c captures `timerVal` at that edge and discards the write data. Software captures never set a flag.
- R5: A channel in hardware mode ignores writes to its capture addresses. A channel in software mode ignores its pin, so there is no capture and no flag.
- R6: A hardware capture on channel c sets flag bit c, and the flag stays set. Writing address 9 clears each flag whose data bit is 1. Bits written as 0 leave their flags alone. If a set and a clear hit the same bit in the same cycle, the set wins.
- R7: Reads are combinational. Address 2c returns bits 7:0 of capture register c, and 2c+1 returns bits 15:8. Address 8 returns the configuration byte and address 9 returns the flags.
- R8: A read in the same cycle as a capture into that register returns the old value. The new value is visible from the next cycle on.
- R9: A capture on one channel leaves the other three capture registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timerVal | input | 16 | Current timer count |
| capPin | input | 4 | Asynchronous capture pins, one per channel |
| busSel | input | 1 | Register access valid |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data; 0 when no read is in progress |
| irqFlag | output | 4 | Sticky hardware-capture flags |

## Verification
The bench sweeps every channel, both edge polarities and both modes. For each combination it drives matching and opposite edges and both kinds of write. It then compares all four registers and the flags with a model kept in the bench.

The timer value changes every cycle, so a synchroniser one stage short or long latches a neighbouring count. A polarity decode that is inverted captures on the wrong edge. A mode gate that leaks lets writes or pins corrupt a channel they should not reach.

Two same-cycle collisions get their own checks. A read that collides with a capture must still return the old value. A flag clear that collides with a flag set must lose; a design that let the clear win would drop an interrupt.

// File: rtl/capture_pkg.sv
package capture_pkg;
  localparam int CAP_CH  = 4;
  localparam int TMR_W   = 16;
  localparam int BUS_W   = 8;
  localparam int ADDR_W  = $clog2(2 * CAP_CH + 2);
  localparam int CFG_W   = 2 * CAP_CH;
  localparam logic [ADDR_W-1:0] CFG_ADDR  = ADDR_W'(2 * CAP_CH);
  localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(2 * CAP_CH + 1);

  typedef struct packed {
    logic [CAP_CH-1:0] capLoad;
  } capStrobes_t;
endpackage

// File: rtl/capture_pin_sync.sv
module capture_pin_sync
  import capture_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CAP_CH-1:0] pinIn,
  output logic [CAP_CH-1:0] riseEdge,
  output logic [CAP_CH-1:0] fallEdge
);
  logic [CAP_CH-1:0] meta, synced, prevLvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta    <= '0;
      synced  <= '0;
      prevLvl <= '0;
    end else begin
      meta    <= pinIn;
      synced  <= meta;
      prevLvl <= synced;
    end
  end

  assign riseEdge = synced & ~prevLvl;
  assign fallEdge = ~synced & prevLvl;
endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import capture_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CAP_CH-1:0] riseEdge,
  input  logic [CAP_CH-1:0] fallEdge,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output capStrobes_t       strb,
  output logic [BUS_W-1:0]  ctlRdByte,
  output logic              ctlRdHit,
  output logic [CAP_CH-1:0] flagQ
);
  logic [CFG_W-1:0]  cfgQ;
  logic [CAP_CH-1:0] cfgMode, cfgFall, hwHit, swHit, flagClr;
  logic              wrStrobe;

  assign cfgMode  = cfgQ[CAP_CH-1:0];
  assign cfgFall  = cfgQ[CFG_W-1:CAP_CH];
  assign wrStrobe = busSel && busWr;

  for (genvar c = 0; c < CAP_CH; c++) begin : g_ch
    assign hwHit[c]   = cfgFall[c] ? fallEdge[c] : riseEdge[c];
    assign swHit[c]   = wrStrobe && (busAddr == ADDR_W'(2 * c));
    assign flagClr[c] = wrStrobe && (busAddr == FLAG_ADDR) && busWdata[c];
    assign strb.capLoad[c] = cfgMode[c] ? swHit[c] : hwHit[c];

    // R6: a set flag stays set unless software clears it
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flagQ[c] && !flagClr[c]) |=> flagQ[c]);
    // R4: software-mode channels never raise their flag
    p_flag_hw_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfgMode[c] && !flagClr[c]) |=> (flagQ[c] == $past(flagQ[c])));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgQ  <= '0;
      flagQ <= '0;
    end else begin
      if (wrStrobe && busAddr == CFG_ADDR) cfgQ <= busWdata[CFG_W-1:0];
      flagQ <= (flagQ & ~flagClr) | (hwHit & ~cfgMode);
    end
  end

  always_comb begin
    ctlRdHit  = (busAddr == CFG_ADDR) || (busAddr == FLAG_ADDR);
    ctlRdByte = (busAddr == CFG_ADDR) ? BUS_W'(cfgQ) : BUS_W'(flagQ);
  end
endmodule

// File: rtl/capture_datapath.sv
module capture_datapath
  import capture_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  capStrobes_t       strb,
  input  logic [TMR_W-1:0]  timerVal,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [BUS_W-1:0]  capRdByte
);
  localparam int IDX_W = ADDR_W - 1;

  logic [TMR_W-1:0] capReg [CAP_CH];

  for (genvar c = 0; c < CAP_CH; c++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                capReg[c] <= '0;
      else if (strb.capLoad[c])  capReg[c] <= timerVal;
    end

    // R2: a load strobe stores the timer value of that edge
    p_capture_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
      strb.capLoad[c] |=> (capReg[c] == $past(timerVal)));
    // R9: without its strobe a register keeps its value
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !strb.capLoad[c] |=> $stable(capReg[c]));
  end

  always_comb begin
    capRdByte = '0;
    for (int c = 0; c < CAP_CH; c++) begin
      if (busAddr[ADDR_W-1:1] == IDX_W'(c))
        capRdByte = busAddr[0] ? capReg[c][TMR_W-1:BUS_W] : capReg[c][BUS_W-1:0];
    end
  end
endmodule

// File: rtl/capture_unit.sv
module capture_unit
  import capture_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TMR_W-1:0]  timerVal,
  input  logic [CAP_CH-1:0] capPin,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic [CAP_CH-1:0] irqFlag
);
  logic [CAP_CH-1:0] riseEdge, fallEdge;
  capStrobes_t       strb;
  logic [BUS_W-1:0]  ctlRdByte, capRdByte;
  logic              ctlRdHit;

  capture_pin_sync u_sync (
    .clk(clk), .rst_n(rst_n), .pinIn(capPin),
    .riseEdge(riseEdge), .fallEdge(fallEdge)
  );

  capture_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .riseEdge(riseEdge), .fallEdge(fallEdge),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .strb(strb), .ctlRdByte(ctlRdByte), .ctlRdHit(ctlRdHit), .flagQ(irqFlag)
  );

  capture_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .timerVal(timerVal),
    .busAddr(busAddr), .capRdByte(capRdByte)
  );

  assign busRdata = (busSel && !busWr) ? (ctlRdHit ? ctlRdByte : capRdByte) : '0;
endmodule

// File: tb/capture_unit_test.sv
module capture_unit_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] timerVal = '0;
  logic [3:0]  capPin = '0;
  logic        busSel = 0, busWr = 0;
  logic [3:0]  busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [3:0]  irqFlag;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] expCap [4];
  logic [3:0]  expFlag;

  capture_unit uut (.*);

  always #5 clk = ~clk;

  task automatic chk(string req, string what, int act, int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic busRead(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = a;
    #1 d = busRdata;
    busSel = 0;
  endtask

  task automatic busWrite(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0;
  endtask

  task automatic checkAll(string req);
    logic [7:0] lo, hi, fl;
    for (int c = 0; c < 4; c++) begin
      busRead(4'(2*c), lo);
      busRead(4'(2*c+1), hi);
      chk(req, $sformatf("cap%0d", c), {hi, lo}, expCap[c]);
    end
    busRead(4'd9, fl);
    chk(req, "flag reg", fl, expFlag);
    chk(req, "irqFlag", irqFlag, expFlag);
  endtask

  // pin change at a negedge; captured value is base+2 (edge k+2)
  task automatic pinEdge(int c, bit lvl, logic [15:0] base, bit hit);
    @(negedge clk);
    capPin[c] = lvl; timerVal = base;
    @(negedge clk); timerVal = base + 1;
    @(negedge clk); timerVal = base + 2;
    @(negedge clk); timerVal = base + 3;
    if (hit) begin
      expCap[c] = base + 2;
      expFlag[c] = 1'b1;
    end
  endtask

  task automatic swCap(int c, logic [15:0] tv, logic [7:0] d, bit hit);
    @(negedge clk);
    timerVal = tv;
    busSel = 1; busWr = 1; busAddr = 4'(2*c); busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0; timerVal = tv + 16'h0111;
    if (hit) expCap[c] = tv;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    for (int c = 0; c < 4; c++) expCap[c] = '0;
    expFlag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    checkAll("R1");
    busRead(4'd8, rd);
    chk("R1", "cfg", rd, 0);

    for (int c = 0; c < 4; c++) begin
      for (int pol = 0; pol < 2; pol++) begin
        logic [15:0] base;
        base = 16'h1000 * (c + 1) + 16'h0200 * pol;
        // hardware mode, polarity per R3
        busWrite(4'd8, 8'(pol << (4 + c)));
        busRead(4'd8, rd);
        chk("R7", "cfg readback", rd, pol << (4 + c));
        pinEdge(c, 1, base, pol == 0);
        checkAll(pol == 0 ? "R2" : "R3");
        pinEdge(c, 0, base + 16'h0010, pol == 1);
        checkAll(pol == 1 ? "R3" : "R9");
        // R6: zero write leaves flags, one clears
        busWrite(4'd9, 8'h00);
        checkAll("R6");
        busWrite(4'd9, 8'(1 << c));
        expFlag[c] = 1'b0;
        checkAll("R6");
        // R5: write in hardware mode ignored
        swCap(c, base + 16'h0020, 8'h5A, 0);
        checkAll("R5");
        // R4: software mode capture, data discarded, no flag
        busWrite(4'd8, 8'(1 << c) | 8'(pol << (4 + c)));
        swCap(c, base + 16'h0030, 8'hA5, 1);
        checkAll("R4");
        busWrite(4'(2*c+1), 8'hC3);
        checkAll("R4");
        // R5: pins ignored in software mode
        pinEdge(c, 1, base + 16'h0040, 0);
        pinEdge(c, 0, base + 16'h0050, 0);
        checkAll("R5");
      end
    end

    // R8: read colliding with capture returns the old value
    busWrite(4'd8, 8'h00);
    @(negedge clk); capPin[0] = 1; timerVal = 16'h7001;
    @(negedge clk); timerVal = 16'h7002;
    @(negedge clk); timerVal = 16'h7003;
    busSel = 1; busWr = 0; busAddr = 4'd0;
    #1 rd = busRdata;
    chk("R8", "old low byte", rd, expCap[0][7:0]);
    @(negedge clk); busSel = 0; timerVal = 16'h7004;
    expCap[0] = 16'h7003; expFlag[0] = 1'b1;
    checkAll("R8");

    // R6: set wins over same-cycle clear
    pinEdge(0, 0, 16'h7100, 0);
    busWrite(4'd9, 8'h0F);
    expFlag = '0;
    @(negedge clk); capPin[0] = 1; timerVal = 16'h7201;
    @(negedge clk); timerVal = 16'h7202;
    @(negedge clk); timerVal = 16'h7203;
    busSel = 1; busWr = 1; busAddr = 4'd9; busWdata = 8'h01;
    @(negedge clk); busSel = 0; busWr = 0;
    expCap[0] = 16'h7203; expFlag[0] = 1'b1;
    checkAll("R6");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule